// File: doc/BRIEF.md
# Indexed RTC Register Port

This block is the host face of a real-time-clock register file. A byte-wide bus with a single address bit reaches 128 bytes of clock and non-volatile configuration storage. A write to the even address selects a byte. An access to the odd address reads or writes the selected byte. Most bytes are plain storage. Four control and status bytes at fixed indices behave differently. Register A holds a rate field and an update-in-progress flag. Register B holds the set-mode bit and the enables. Register C is the interrupt status byte. Register D is a constant status byte.

Time counting and rate generation happen outside this block. Those engines OR flag bits into the status byte through `flag_set`, and they move the update-in-progress flag through `uip_set` and `uip_clr`. When the host changes the time while the clock is running, the block raises `clk_load` so that the time engine reloads its counters from the stored time bytes. The block also keeps a running 16-bit sum of a configuration range. The host reads that sum at two fixed indices.

Top module: `rtc_index_port`

## Requirements
- R1: A write to the even address (`host_addr`=0) loads the index with `host_wdata[6:0]`. Later odd-address accesses read or write the byte at that index.
- R2: A read from the even address returns 0xFF and changes no state.
- R3: Register A (index 10) takes host bits 6..0 on a write. Host writes never change bit 7, the update-in-progress flag.
- R4: Host writes to register C (index 12) and register D (index 13) are ignored. Register D always reads 0x80.
- R5: A read of register C returns its current value. At the next edge the register clears and `irq` falls. Flags that arrive on `flag_set` in the same cycle as the read remain set after the clear.
- R6: At every clock edge the bits of `flag_set` are ORed into register C. `irq` is high exactly when register C is nonzero.
- R7: A host write to register B (index 11) with bit 7 set clears the update-in-progress flag. `uip_clr` clears the flag. `uip_set` sets the flag only while the stored B bit 7 is clear. A B write with bit 7 set takes priority over `uip_clr`, and `uip_clr` takes priority over `uip_set`.
- R8: A host write to a time byte (index 0, 2, 4, 6, 7, 8 or 9) made while B bit 7 is clear gives a one-cycle `clk_load` pulse in the cycle after the write. The same write made while B bit 7 is set gives no pulse.
- R9: A write to register B with bit 7 clear, made while the stored bit 7 is set, gives a one-cycle `clk_load` pulse in the next cycle. `set_mode` always reflects the stored B bit 7.
- R10: After reset, A=0x26, B=0x02, C=0x00 and D=0x80. Every other byte reads 0, the index is 0 and `irq` is low.
- R11: Index 46 reads the high byte and index 47 reads the low byte of the 16-bit sum of bytes 16 through 45. The sum follows every write in that range, and host writes to indices 46 and 47 are ignored.
- R12: Every other index is read/write storage that returns the last byte written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 1 | 0 = index port, 1 = data port |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational, valid while `host_sel` is high |
| flag_set | input | 8 | Flag bits ORed into register C at each clock edge |
| uip_set | input | 1 | Request to set the update-in-progress flag |
| uip_clr | input | 1 | Request to clear the update-in-progress flag |
| irq | output | 1 | Level interrupt, high while register C is nonzero |
| set_mode | output | 1 | Stored bit 7 of register B |
| clk_load | output | 1 | One-cycle request to reload the time engine from the time bytes |

## Verification
The bench keeps a reference model of the register file and, for the checksum, adds up bytes 16 through 45 from scratch instead of keeping a running sum. An incremental sum that drops the old byte value therefore drifts from the model, and writes to indices 46 and 47 show up if the design stores them. Directed cases target a read of register C in the same cycle that new flags arrive: a design that clears after merging loses the new flag and drops `irq` too early. The same directed pass writes register A with the flag set and with it clear, so a design that lets the host write bit 7 fails. The random phase mixes set-mode changes with time-byte writes, which exposes a `clk_load` that ignores set mode or misses the set-to-clear transition of register B.

// File: rtl/rtc_idx_pkg.sv
`timescale 1ns/1ps
package rtc_idx_pkg;
   localparam int unsigned BYTE_W      = 8;
   localparam int unsigned IDX_CTRL_A  = 10;
   localparam int unsigned IDX_CTRL_B  = 11;
   localparam int unsigned IDX_STAT_C  = 12;
   localparam int unsigned IDX_STAT_D  = 13;
   localparam logic [BYTE_W-1:0] EVEN_READ_VAL = 8'hFF;

   // time and date bytes that feed the running clock
   function automatic logic is_clock_field(input int unsigned i);
      return (i == 0) || (i == 2) || (i == 4) || (i >= 6 && i <= 9);
   endfunction
endpackage

// File: rtl/rtc_byte_store.sv
`timescale 1ns/1ps
module rtc_byte_store #(
   parameter int unsigned IDX_W = 7,
   parameter int unsigned DW    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   logic [DW-1:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we) begin
         mem_q[idx] <= wdata;
      end
   end

   assign rdata = mem_q[idx];
endmodule

// File: rtl/rtc_csum.sv
`timescale 1ns/1ps
module rtc_csum #(
   parameter int unsigned IDX_W  = 7,
   parameter int unsigned DW     = 8,
   parameter int unsigned SUM_W  = 16,
   parameter int unsigned FIRST  = 16,
   parameter int unsigned LAST   = 45
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [IDX_W-1:0] idx,
   input  logic [DW-1:0]    old_byte,
   input  logic [DW-1:0]    new_byte,
   output logic [SUM_W-1:0] sum
);
   logic             in_range;
   logic [SUM_W-1:0] sum_q;

   assign in_range = (32'(idx) >= FIRST) && (32'(idx) <= LAST);

   // incremental update: drop the old byte, add the new one
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                sum_q <= '0;
      else if (wr && in_range)   sum_q <= sum_q - SUM_W'(old_byte) + SUM_W'(new_byte);
   end

   assign sum = sum_q;

   AST_CSUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(sum_q)); // R11
endmodule

// File: rtl/rtc_ctrl_regs.sv
`timescale 1ns/1ps
module rtc_ctrl_regs #(
   parameter int unsigned DW    = 8,
   parameter logic [7:0]  A_RST = 8'h26,
   parameter logic [7:0]  B_RST = 8'h02
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_we,
   input  logic          host_re,
   input  logic          hit_a,
   input  logic          hit_b,
   input  logic          hit_c,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] flag_set,
   input  logic          uip_set,
   input  logic          uip_clr,
   output logic [DW-1:0] reg_a,
   output logic [DW-1:0] reg_b,
   output logic [DW-1:0] reg_c,
   output logic          irq
);
   localparam int unsigned TOP = DW - 1;

   logic [DW-1:0] a_q, b_q, c_q, a_n, b_n, c_n;
   logic          irq_q, irq_n, rd_c, b_set_wr;

   assign rd_c     = host_re && hit_c;
   assign b_set_wr = host_we && hit_b && wdata[TOP];

   always_comb begin
      a_n = a_q;
      b_n = b_q;
      if (host_we && hit_a) a_n[TOP-1:0] = wdata[TOP-1:0];
      if (host_we && hit_b) b_n = wdata;
      if (b_set_wr)                  a_n[TOP] = 1'b0;
      else if (uip_clr)              a_n[TOP] = 1'b0;
      else if (uip_set && !b_q[TOP]) a_n[TOP] = 1'b1;
      c_n   = (rd_c ? '0 : c_q) | flag_set;
      irq_n = (rd_c ? 1'b0 : irq_q) | (|flag_set);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q   <= A_RST;
         b_q   <= B_RST;
         c_q   <= '0;
         irq_q <= 1'b0;
      end else begin
         a_q   <= a_n;
         b_q   <= b_n;
         c_q   <= c_n;
         irq_q <= irq_n;
      end
   end

   assign reg_a = a_q;
   assign reg_b = b_q;
   assign reg_c = c_q;
   assign irq   = irq_q;

   AST_UIP_HOST_RO: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && hit_a && !uip_set && !uip_clr) |=> (a_q[TOP] == $past(a_q[TOP]))); // R3
   AST_C_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && hit_c && flag_set == '0) |=> $stable(c_q)); // R4
   AST_C_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_c |=> (c_q == $past(flag_set))); // R5
   AST_IRQ_TRACKS_C: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q == (c_q != '0)); // R6
   AST_SET_KILLS_UIP: assert property (@(posedge clk) disable iff (!rst_n)
      b_set_wr |=> !a_q[TOP]); // R7
endmodule

// File: rtl/rtc_index_port.sv
`timescale 1ns/1ps
module rtc_index_port
   import rtc_idx_pkg::*;
#(
   parameter int unsigned IDX_W      = 7,
   parameter bit          CSUM_EN    = 1'b1,
   parameter int unsigned CSUM_FIRST = 16,
   parameter int unsigned CSUM_LAST  = 45,
   parameter int unsigned CSUM_HI    = 46,
   parameter int unsigned CSUM_LO    = 47,
   parameter logic [7:0]  A_RST      = 8'h26,
   parameter logic [7:0]  B_RST      = 8'h02,
   parameter logic [7:0]  D_VAL      = 8'h80
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       host_sel,
   input  logic       host_wr,
   input  logic       host_addr,
   input  logic [7:0] host_wdata,
   output logic [7:0] host_rdata,
   input  logic [7:0] flag_set,
   input  logic       uip_set,
   input  logic       uip_clr,
   output logic       irq,
   output logic       set_mode,
   output logic       clk_load
);
   localparam int unsigned DW        = BYTE_W;
   localparam int unsigned SUM_W     = 2 * DW;
   localparam int unsigned NUM_BYTES = 1 << IDX_W;

   if (IDX_W < 6 || IDX_W > 7) begin : g_bad_idx
      $error("IDX_W must be 6 or 7");
   end
   if (CSUM_EN && (CSUM_LAST < CSUM_FIRST || CSUM_FIRST <= IDX_STAT_D)) begin : g_bad_rng
      $error("checksum range must follow the control bytes");
   end
   if (CSUM_EN && (CSUM_HI >= NUM_BYTES || CSUM_LO >= NUM_BYTES ||
                   CSUM_HI <= CSUM_LAST || CSUM_LO <= CSUM_LAST || CSUM_HI == CSUM_LO)) begin : g_bad_dst
      $error("checksum bytes must lie above the range and inside the array");
   end

   logic [IDX_W-1:0] idx_q;
   logic             wr_idx, wr_dat, rd_dat;
   logic             hit_a, hit_b, hit_c, hit_d, hit_ctl, time_hit, csum_hit;
   logic [DW-1:0]    reg_a, reg_b, reg_c, store_rd, csum_byte;
   logic             store_we, load_q, load_n;

   assign wr_idx = host_sel &&  host_wr && !host_addr;
   assign wr_dat = host_sel &&  host_wr &&  host_addr;
   assign rd_dat = host_sel && !host_wr &&  host_addr;

   assign hit_a    = (32'(idx_q) == IDX_CTRL_A);
   assign hit_b    = (32'(idx_q) == IDX_CTRL_B);
   assign hit_c    = (32'(idx_q) == IDX_STAT_C);
   assign hit_d    = (32'(idx_q) == IDX_STAT_D);
   assign hit_ctl  = hit_a || hit_b || hit_c || hit_d;
   assign time_hit = is_clock_field(32'(idx_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx_q <= '0;
      else if (wr_idx) idx_q <= host_wdata[IDX_W-1:0];
   end

   rtc_ctrl_regs #(.DW(DW), .A_RST(A_RST), .B_RST(B_RST)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .host_we  (wr_dat),
      .host_re  (rd_dat),
      .hit_a    (hit_a),
      .hit_b    (hit_b),
      .hit_c    (hit_c),
      .wdata    (host_wdata),
      .flag_set (flag_set),
      .uip_set  (uip_set),
      .uip_clr  (uip_clr),
      .reg_a    (reg_a),
      .reg_b    (reg_b),
      .reg_c    (reg_c),
      .irq      (irq)
   );

   assign store_we = wr_dat && !hit_ctl && !csum_hit;

   rtc_byte_store #(.IDX_W(IDX_W), .DW(DW)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (store_we),
      .idx   (idx_q),
      .wdata (host_wdata),
      .rdata (store_rd)
   );

   if (CSUM_EN) begin : g_csum
      logic [SUM_W-1:0] sum;
      rtc_csum #(.IDX_W(IDX_W), .DW(DW), .SUM_W(SUM_W),
                 .FIRST(CSUM_FIRST), .LAST(CSUM_LAST)) u_csum (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr       (wr_dat),
         .idx      (idx_q),
         .old_byte (store_rd),
         .new_byte (host_wdata),
         .sum      (sum)
      );
      assign csum_hit  = (32'(idx_q) == CSUM_HI) || (32'(idx_q) == CSUM_LO);
      assign csum_byte = (32'(idx_q) == CSUM_HI) ? sum[SUM_W-1:DW] : sum[DW-1:0];
   end else begin : g_no_csum
      assign csum_hit  = 1'b0;
      assign csum_byte = '0;
   end

   always_comb begin
      if (!host_addr)    host_rdata = EVEN_READ_VAL;
      else if (hit_a)    host_rdata = reg_a;
      else if (hit_b)    host_rdata = reg_b;
      else if (hit_c)    host_rdata = reg_c;
      else if (hit_d)    host_rdata = D_VAL;
      else if (csum_hit) host_rdata = csum_byte;
      else               host_rdata = store_rd;
   end

   // reload request: time byte written while running, or set mode released
   assign load_n = wr_dat && ((time_hit && !reg_b[DW-1]) ||
                              (hit_b && reg_b[DW-1] && !host_wdata[DW-1]));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) load_q <= 1'b0;
      else        load_q <= load_n;
   end

   assign clk_load = load_q;
   assign set_mode = reg_b[DW-1];

   AST_LOAD_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      clk_load |-> (!set_mode && $past(host_sel && host_wr && host_addr))); // R8
   AST_EVEN_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (host_sel && !host_wr && !host_addr && flag_set == '0 && !uip_set && !uip_clr)
         |=> ($stable(reg_a) && $stable(reg_b) && $stable(idx_q))); // R2
endmodule

// File: tb/sim_rtc_index_port.sv
`timescale 1ns/1ps
module sim_rtc_index_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_sel = 1'b0, host_wr = 1'b0, host_addr = 1'b0;
   logic [7:0] host_wdata = '0, flag_set = '0;
   logic       uip_set = 1'b0, uip_clr = 1'b0;
   logic [7:0] host_rdata;
   logic       irq, set_mode, clk_load;

   always #2 clk = ~clk;

   rtc_index_port u0 (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .flag_set(flag_set), .uip_set(uip_set), .uip_clr(uip_clr),
      .irq(irq), .set_mode(set_mode), .clk_load(clk_load)
   );

   int         n_vec = 0, n_bad = 0;
   bit         done = 1'b0;
   logic [7:0] m [128];
   logic [6:0] midx;
   logic       mirq;

   function automatic logic [15:0] ref_sum();
      logic [15:0] s = '0;
      for (int i = 16; i <= 45; i++) s = s + 16'(m[i]);
      return s;
   endfunction

   function automatic logic [7:0] ref_read(input logic [6:0] i);
      logic [15:0] s = ref_sum();
      if (i == 7'd46) return s[15:8];
      if (i == 7'd47) return s[7:0];
      return m[i];
   endfunction

   function automatic bit is_time(input logic [6:0] i);
      return (i == 0) || (i == 2) || (i == 4) || (i >= 6 && i <= 9);
   endfunction

   function automatic string req_of(input logic [6:0] i);
      if (i == 10) return "R3";
      if (i == 11) return "R7";
      if (i == 12) return "R5";
      if (i == 13) return "R4";
      if (i == 46 || i == 47) return "R11";
      if (i < 16) return "R12";
      return "R1";
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 128; i++) m[i] = '0;
      m[10] = 8'h26; m[11] = 8'h02; m[13] = 8'h80;
      midx = '0; mirq = 1'b0;
   endtask

   task automatic step(input logic s, input logic w, input logic a, input logic [7:0] wd,
                       input logic [7:0] fl, input logic us, input logic uc);
      logic       b7, rdc, lod, bset, na7;
      string      lreq;
      @(negedge clk);
      host_sel = s; host_wr = w; host_addr = a; host_wdata = wd;
      flag_set = fl; uip_set = us; uip_clr = uc;
      #1;
      if (s && !w) chk(a ? req_of(midx) : "R2", host_rdata, a ? ref_read(midx) : 8'hFF);
      b7 = m[11][7]; lod = 1'b0; bset = 1'b0; lreq = "R8";
      rdc = s && !w && a && (midx == 12);
      na7 = m[10][7];
      if (s && w && !a) midx = wd[6:0];
      else if (s && w && a) begin
         case (midx)
            7'd10: m[10][6:0] = wd[6:0];
            7'd11: begin
               if (wd[7]) bset = 1'b1;
               else if (b7) begin lod = 1'b1; lreq = "R9"; end
               m[11] = wd;
            end
            7'd12, 7'd13, 7'd46, 7'd47: ;
            default: begin
               m[midx] = wd;
               if (is_time(midx) && !b7) lod = 1'b1;
            end
         endcase
      end
      if (bset)           na7 = 1'b0;
      else if (uc)        na7 = 1'b0;
      else if (us && !b7) na7 = 1'b1;
      m[10][7] = na7;
      m[12] = (rdc ? 8'h00 : m[12]) | fl;
      mirq  = (rdc ? 1'b0 : mirq) | (fl != 0);
      @(posedge clk); #1;
      chk("R6", {7'd0, irq}, {7'd0, mirq});
      chk(lreq, {7'd0, clk_load}, {7'd0, lod});
      chk("R9", {7'd0, set_mode}, {7'd0, m[11][7]});
   endtask

   task automatic idle(); step(0, 0, 0, 8'h00, 8'h00, 0, 0); endtask
   task automatic setix(input logic [6:0] i); step(1, 1, 0, {1'b0, i}, 0, 0, 0); endtask
   task automatic wrd(input logic [7:0] d); step(1, 1, 1, d, 0, 0, 0); endtask
   task automatic rdd(); step(1, 0, 1, 8'h00, 0, 0, 0); endtask

   function automatic logic [6:0] pick_idx();
      logic [6:0] tbl [14] = '{7'd0, 7'd2, 7'd4, 7'd7, 7'd9, 7'd10, 7'd11,
                               7'd12, 7'd13, 7'd16, 7'd45, 7'd46, 7'd47, 7'd20};
      int r = int'($urandom % 18);
      if (r < 14) return tbl[r];
      return 7'($urandom);
   endfunction

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10: reset values of every control byte and of plain storage
      rdd();
      setix(10); rdd(); setix(11); rdd(); setix(12); rdd(); setix(13); rdd();
      setix(46); rdd(); setix(47); rdd(); setix(30); rdd();
      // R1: index takes the low 7 bits only
      step(1, 1, 0, 8'hA5, 0, 0, 0); wrd(8'h5C); setix(37); rdd(); setix(37); rdd();
      // R2: even read returns FF
      step(1, 0, 0, 8'h00, 0, 0, 0);
      // R3: host cannot write the update flag in either direction
      setix(10); wrd(8'hFF); rdd();
      step(0, 0, 0, 0, 0, 1, 0); wrd(8'h05); rdd();
      // R4: C and D ignore writes
      setix(12); wrd(8'hFF); rdd(); setix(13); wrd(8'h00); rdd();
      // R5, R6: flag merge, read-to-clear with same-cycle flags
      step(0, 0, 0, 0, 8'h40, 0, 0); setix(12);
      step(1, 0, 1, 0, 8'h10, 0, 0); rdd(); rdd();
      // R7: set mode blocks uip_set; SET write clears flag
      setix(10); step(0, 0, 0, 0, 0, 1, 0); rdd();
      setix(11); wrd(8'h82); step(0, 0, 0, 0, 0, 1, 0); setix(10); rdd();
      // R8: time write under set mode gives no reload
      setix(2); wrd(8'h59);
      // R9: leaving set mode requests a reload
      setix(11); wrd(8'h02);
      // R8: time write while running reloads
      setix(4); wrd(8'h12); setix(9); wrd(8'h24); setix(1); wrd(8'h30);
      // R11: checksum tracks range ends and ignores its own bytes
      setix(16); wrd(8'hFF); setix(45); wrd(8'hFE); setix(16); wrd(8'h01);
      setix(46); wrd(8'h77); rdd(); setix(47); wrd(8'h77); rdd();
      // R12: plain bytes outside all special ranges
      setix(100); wrd(8'h3C); idle(); rdd();
      // random mix
      for (int k = 0; k < 6000; k++) begin
         logic s = ($urandom % 4) != 0;
         logic w = $urandom % 2;
         logic a = $urandom % 3 != 0;
         logic [7:0] d = 8'($urandom);
         logic [7:0] fl = (($urandom % 8) == 0) ? 8'($urandom) : 8'h00;
         logic us = ($urandom % 10) == 0;
         logic uc = ($urandom % 12) == 0;
         if (s && w && !a) d = {1'b0, pick_idx()};
         step(s, w, a, d, fl, us, uc);
      end
      idle();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule